// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a register-mapped asynchronous serial port. It has an eight-byte queue for outgoing bytes and another for incoming bytes. Software pushes bytes by writing the transmit data register, and pops them by reading the receive data register. Each data register reports in bit 31 whether its queue is full (transmit) or empty (receive). Frames always carry eight data bits, least significant bit first, with no parity. They end with one or two high stop bits.

A 16-bit divisor sets the bit time to divisor+1 clock cycles. The same divisor drives the transmitter and the receiver. The receiver looks for a falling edge on the synchronised line. It then waits half a bit to confirm the start bit and samples each later bit once per bit time. A frame is accepted only when its stop bit is high.

Interrupts come from queue occupancy, not from individual events. Each direction compares its queue level against its own 3-bit threshold. The pending conditions are ANDed with an enable mask, and the results are ORed onto one level-sensitive interrupt line.

Top module: `wmu_uart`

## Requirements
- R1: After reset, the transmit and receive control registers and the interrupt enable register read 0, the divisor reads the DIV_RESET parameter, the serial output is high and the interrupt output is low.
- R2: A byte written to the transmit data register (word 0, bits 7:0) is sent once transmit is enabled (word 2 bit 0). The frame is one low start bit, then the data bits least significant first, then a high stop bit. Every bit lasts divisor+1 cycles.
- R3: Reading the transmit data register returns bit 31 = 1 exactly when eight bytes are queued, with all other bits 0. A write while the queue is full is dropped, so no ninth frame is sent.
- R4: With word 2 bit 1 clear, the start edges of back-to-back frames are at least 10 and fewer than 11 bit times apart. With that bit set (two stop bits), they are at least 11 and fewer than 12 bit times apart.
- R5: Reading the receive data register (word 1) pops the oldest received byte into bits 7:0 with bit 31 = 0. When the queue is empty, the read returns exactly 0x8000_0000.
- R6: A frame whose stop bit is low is discarded. Frames that arrive while receive is disabled (word 3 bit 0 = 0) are ignored.
- R7: A queue never holds more than eight bytes. A byte received while the receive queue is full is discarded, and the eight older bytes come out in arrival order.
- R8: The pending register (word 5) is read-only, and writes to it have no effect. Bit 0 is set while the transmit count is below the transmit threshold (word 2 bits 18:16). Bit 1 is set while the receive count is above the receive threshold (word 3 bits 18:16).
- R9: The interrupt output is high exactly when some bit is set both in the pending register and in the enable register (word 4, bit 0 transmit, bit 1 receive).
- R10: Register fields read back as written: word 2 bits 18:16, 1 and 0; word 3 bits 18:16 and 0; word 4 bits 1:0; word 6 bits 15:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | One-cycle write strobe |
| rdEn | input | 1 | One-cycle read strobe; data is valid on the following cycle |
| addr | input | 3 | Word index of the register (byte offset divided by 4) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| rxLine | input | 1 | Serial input, idle high |
| txLine | output | 1 | Serial output, idle high |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that read and write strobes are one-cycle pulses that are never both raised in the same cycle. They also assume that the address is stable while a strobe is high. The stimulus meets this by driving every register access from a task that changes signals only on the falling clock edge and drops the strobe after one cycle. The serial input is likewise driven only at falling edges, at exactly the programmed bit rate, so the receiver's mid-bit sampling never falls on a bit boundary.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int WM_W   = 3;
  localparam int DIV_W  = 16;

  localparam logic [2:0] SEL_TXD = 3'd0;
  localparam logic [2:0] SEL_RXD = 3'd1;
  localparam logic [2:0] SEL_TXC = 3'd2;
  localparam logic [2:0] SEL_RXC = 3'd3;
  localparam logic [2:0] SEL_IE  = 3'd4;
  localparam logic [2:0] SEL_IP  = 3'd5;
  localparam logic [2:0] SEL_DIV = 3'd6;

  typedef struct packed {
    logic             txEn;
    logic             twoStop;
    logic [WM_W-1:0]  txWm;
    logic             rxEn;
    logic [WM_W-1:0]  rxWm;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txByte;
  } strobe_t;
endpackage

// File: rtl/wmu_fifo.sv
module wmu_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wmu_ctrl.sv
module wmu_ctrl
  import wmu_pkg::*;
#(
  parameter int               CNT_W     = 4,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wrData,
  input  logic             txFull,
  input  logic             rxEmpty,
  input  logic [7:0]       rxHead,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output cfg_t             cfg,
  output strobe_t          strobes,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  logic [1:0] ie, ip;
  logic [REG_W-1:0] rdNext;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[31:19];

  // Occupancy watermarks: transmit below threshold, receive above threshold
  assign ip[0] = txCount < CNT_W'(cfg.txWm);
  assign ip[1] = rxCount > CNT_W'(cfg.rxWm);
  assign irq   = |(ip & ie);

  assign strobes.txPush = wrEn && (addr == SEL_TXD) && !txFull;
  assign strobes.rxPop  = rdEn && (addr == SEL_RXD) && !rxEmpty;
  assign strobes.txByte = wrData[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      cfg.div <= DIV_RESET;
      ie      <= '0;
    end else if (wrEn) begin
      case (addr)
        SEL_TXC: begin
          cfg.txEn    <= wrData[0];
          cfg.twoStop <= wrData[1];
          cfg.txWm    <= wrData[18:16];
        end
        SEL_RXC: begin
          cfg.rxEn <= wrData[0];
          cfg.rxWm <= wrData[18:16];
        end
        SEL_IE:  ie      <= wrData[1:0];
        SEL_DIV: cfg.div <= wrData[15:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      SEL_TXD: rdNext = {txFull, 31'b0};
      SEL_RXD: rdNext = rxEmpty ? 32'h8000_0000 : {24'b0, rxHead};
      SEL_TXC: rdNext = {13'b0, cfg.txWm, 14'b0, cfg.twoStop, cfg.txEn};
      SEL_RXC: rdNext = {13'b0, cfg.rxWm, 15'b0, cfg.rxEn};
      SEL_IE:  rdNext = {30'b0, ie};
      SEL_IP:  rdNext = {30'b0, ip};
      SEL_DIV: rdNext = {16'b0, cfg.div};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/wmu_datapath.sv
module wmu_datapath
  import wmu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          strobes,
  input  logic             rxLine,
  output logic             txLine,
  output logic             txFull,
  output logic             rxEmpty,
  output logic [7:0]       rxHead,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount
);
  localparam int FRAME_W  = BYTE_W + 3;
  localparam int LEFT_W   = $clog2(FRAME_W + 1);
  localparam logic [3:0] STOP_IDX = 4'(BYTE_W + 1);

  logic unusedCfg;
  assign unusedCfg = ^{cfg.txWm, cfg.rxWm};

  // Transmit path
  logic              txEmpty, txStart, txBusy;
  logic [BYTE_W-1:0] txHead;
  logic [FRAME_W-1:0] txShift;
  logic [LEFT_W-1:0] txLeft;
  logic [DIV_W-1:0]  txTimer;

  assign txStart = !txBusy && cfg.txEn && !txEmpty;
  assign txLine  = txBusy ? txShift[0] : 1'b1;

  wmu_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strobes.txPush), .pop(txStart),
    .din(strobes.txByte), .dout(txHead), .count(txCount),
    .full(txFull), .empty(txEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txLeft  <= '0;
      txTimer <= '0;
    end else if (txStart) begin
      txBusy  <= 1'b1;
      txShift <= {2'b11, txHead, 1'b0};
      txLeft  <= cfg.twoStop ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
      txTimer <= '0;
    end else if (txBusy) begin
      if (txTimer == cfg.div) begin
        txTimer <= '0;
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        txLeft  <= txLeft - 1'b1;
        if (txLeft == LEFT_W'(1)) txBusy <= 1'b0;
      end else begin
        txTimer <= txTimer + 1'b1;
      end
    end
  end

  // Receive path
  logic [1:0]        rxSync;
  logic              rxS, rxPrev, rxBusy, rxTick, rxPush, rxFull;
  logic [3:0]        rxIdx;
  logic [DIV_W-1:0]  rxTimer, rxTarget;
  logic [BYTE_W-1:0] rxShift;

  assign rxS      = rxSync[1];
  assign rxTarget = (rxIdx == '0) ? {1'b0, cfg.div[DIV_W-1:1]} : cfg.div;
  assign rxTick   = rxBusy && (rxTimer == rxTarget);
  assign rxPush   = rxTick && (rxIdx == STOP_IDX) && rxS && !rxFull;

  wmu_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(strobes.rxPop),
    .din(rxShift), .dout(rxHead), .count(rxCount),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxPrev  <= 1'b1;
      rxBusy  <= 1'b0;
      rxIdx   <= '0;
      rxTimer <= '0;
      rxShift <= '0;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      rxPrev <= rxS;
      if (!rxBusy) begin
        if (cfg.rxEn && rxPrev && !rxS) begin
          rxBusy  <= 1'b1;
          rxIdx   <= '0;
          rxTimer <= '0;
        end
      end else if (rxTick) begin
        rxTimer <= '0;
        if (rxIdx == '0) begin
          if (rxS) rxBusy <= 1'b0;
          else     rxIdx  <= 4'd1;
        end else if (rxIdx == STOP_IDX) begin
          rxBusy <= 1'b0;
        end else begin
          rxShift <= {rxS, rxShift[BYTE_W-1:1]};
          rxIdx   <= rxIdx + 1'b1;
        end
      end else begin
        rxTimer <= rxTimer + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wmu_uart.sv
module wmu_uart
  import wmu_pkg::*;
#(
  parameter int               FIFO_DEPTH = 8,
  parameter logic [DIV_W-1:0] DIV_RESET  = 16'd15,
  localparam int              CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        rxLine,
  output logic        txLine,
  output logic        irq
);
  cfg_t             cfg;
  strobe_t          strobes;
  logic             txFull, rxEmpty;
  logic [7:0]       rxHead;
  logic [CNT_W-1:0] txCount, rxCount;

  wmu_ctrl #(.CNT_W(CNT_W), .DIV_RESET(DIV_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .txFull(txFull), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .cfg(cfg), .strobes(strobes),
    .rdData(rdData), .irq(irq)
  );

  wmu_datapath #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobes(strobes), .rxLine(rxLine),
    .txLine(txLine), .txFull(txFull), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/wmu_uart_chk.sv
module wmu_uart_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [2:0]       addr,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic             irq,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount
);
  logic unusedChk;
  assign unusedChk = ^wrData[31:2];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd1) |=> (!rdData[31] || rdData[30:0] == 31'b0));

  assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0) |=> (rdData[30:0] == 31'b0));

  assert_ip_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd5) |=> (rdData[31:2] == 30'b0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd4 && wrData[1:0] == 2'b00) |=> !irq);

  assert_div_field_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd6) |=> (rdData[31:16] == 16'b0));
endmodule

bind wmu_uart wmu_uart_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .irq(irq),
  .txCount(txCount), .rxCount(rxCount)
);

// File: tb/wmu_uart_tb.sv
module wmu_uart_tb;
  localparam int DEPTH = 8;
  localparam logic [15:0] DIV_DEF = 16'd15;
  localparam int DV = 3;
  localparam int BP = DV + 1;
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_TXC = 3'd2, A_RXC = 3'd3,
                         A_IE = 3'd4, A_IP = 3'd5, A_DIV = 3'd6;
  localparam int NVEC = 6;
  // {word index, write value, expected readback}
  localparam logic [95:0] REGVEC [NVEC] = '{
    {32'd2, 32'hFFFF_FFFF, 32'h0007_0003},
    {32'd3, 32'hFFFF_FFFF, 32'h0007_0001},
    {32'd4, 32'hFFFF_FFFF, 32'h0000_0003},
    {32'd6, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {32'd6, 32'hABCD_1234, 32'h0000_1234},
    {32'd2, 32'h0005_0002, 32'h0005_0002}
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rxLine = 1'b1;
  logic [2:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txLine, irq;
  int checks = 0, errors = 0;
  bit done = 0;
  longint cyc = 0;

  always #2ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wmu_uart #(.FIFO_DEPTH(DEPTH), .DIV_RESET(DIV_DEF)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxLine(rxLine), .txLine(txLine), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic stopBit);
    @(negedge clk); rxLine = 1'b0;
    repeat (BP - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BP) @(negedge clk);
    end
    rxLine = stopBit;
    repeat (BP) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BP) @(negedge clk);
  endtask

  task automatic captureFrame(output logic [7:0] b, output logic stopHigh,
                              output longint tStart);
    int n = 0;
    b = '0; stopHigh = 1'b0;
    do begin @(negedge clk); n++; end while (txLine && n < 400);
    tStart = cyc;
    if (n >= 400) chk("R2 start bit seen", 32'd0, 32'd1);
    repeat (BP / 2) @(negedge clk);
    chk("R2 start bit low", {31'b0, txLine}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BP) @(negedge clk);
      b[i] = txLine;
    end
    repeat (BP) @(negedge clk);
    stopHigh = txLine;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] b;
    logic sh;
    longint t0, t1;
    int lows;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 txLine idle", {31'b0, txLine}, 32'd1);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    rstN = 1'b1;
    regRead(A_TXC, rd); chk("R1 txctrl", rd, 32'd0);
    regRead(A_RXC, rd); chk("R1 rxctrl", rd, 32'd0);
    regRead(A_IE, rd);  chk("R1 ie", rd, 32'd0);
    regRead(A_DIV, rd); chk("R1 div", rd, {16'b0, DIV_DEF});
    regRead(A_IP, rd);  chk("R8 ip after reset", rd, 32'd0);

    // R10: register field table
    for (int v = 0; v < NVEC; v++) begin
      regWrite(REGVEC[v][66:64], REGVEC[v][63:32]);
      regRead(REGVEC[v][66:64], rd);
      chk("R10 readback", rd, REGVEC[v][31:0]);
    end
    regWrite(A_TXC, 32'd0); regWrite(A_RXC, 32'd0);
    regWrite(A_IE, 32'd0);  regWrite(A_DIV, DV);

    // R2: single frame
    regWrite(A_TXC, 32'd1);
    regWrite(A_TXD, 32'hFFFF_FFA5);
    captureFrame(b, sh, t0);
    chk("R2 data", {24'b0, b}, 32'hA5);
    chk("R2 stop high", {31'b0, sh}, 32'd1);

    // R4: one stop bit spacing
    regWrite(A_TXC, 32'd0);
    regWrite(A_TXD, 32'h3C); regWrite(A_TXD, 32'hC3);
    regWrite(A_TXC, 32'd1);
    captureFrame(b, sh, t0); chk("R4 first byte", {24'b0, b}, 32'h3C);
    captureFrame(b, sh, t1); chk("R4 second byte", {24'b0, b}, 32'hC3);
    chk("R4 one-stop spacing", {31'b0, (t1 - t0 >= 10 * BP) && (t1 - t0 < 11 * BP)}, 32'd1);
    // R4: two stop bits
    regWrite(A_TXC, 32'd2);
    regWrite(A_TXD, 32'h81); regWrite(A_TXD, 32'h7E);
    regWrite(A_TXC, 32'd3);
    captureFrame(b, sh, t0); chk("R4 first byte 2stop", {24'b0, b}, 32'h81);
    captureFrame(b, sh, t1); chk("R4 second byte 2stop", {24'b0, b}, 32'h7E);
    chk("R4 two-stop spacing", {31'b0, (t1 - t0 >= 11 * BP) && (t1 - t0 < 12 * BP)}, 32'd1);

    // R3: full flag and dropped write
    regWrite(A_TXC, 32'd0);
    for (int i = 0; i < 7; i++) regWrite(A_TXD, 32'h10 + i);
    regRead(A_TXD, rd); chk("R3 not full at 7", rd, 32'd0);
    regWrite(A_TXD, 32'h17);
    regRead(A_TXD, rd); chk("R3 full at 8", rd, 32'h8000_0000);
    regWrite(A_TXD, 32'hEE);
    regWrite(A_TXC, 32'd1);
    for (int i = 0; i < 8; i++) begin
      captureFrame(b, sh, t0);
      chk("R3 queued order", {24'b0, b}, 32'h10 + i);
    end
    lows = 0;
    for (int i = 0; i < 14 * BP; i++) begin
      @(negedge clk);
      if (!txLine) lows++;
    end
    chk("R3 ninth byte dropped", lows, 32'd0);
    regRead(A_TXD, rd); chk("R3 not full after drain", rd, 32'd0);

    // R8 / R9: transmit watermark
    regWrite(A_TXC, 32'h0001_0000);
    regRead(A_IP, rd); chk("R8 tx pending when empty", rd, 32'd1);
    regWrite(A_IE, 32'd1);
    chk("R9 irq on tx pending", {31'b0, irq}, 32'd1);
    regWrite(A_TXD, 32'h99);
    regRead(A_IP, rd); chk("R8 tx not pending at count 1", rd, 32'd0);
    chk("R9 irq low without pending", {31'b0, irq}, 32'd0);
    regWrite(A_IE, 32'd0);
    regWrite(A_TXC, 32'h0001_0001);
    captureFrame(b, sh, t0); chk("R2 data after watermark", {24'b0, b}, 32'h99);
    regWrite(A_TXC, 32'd1);

    // R5 / R9: receive
    regWrite(A_RXC, 32'd1);
    regWrite(A_IE, 32'd2);
    sendByte(8'h3C, 1'b1);
    chk("R9 irq on rx pending", {31'b0, irq}, 32'd1);
    regRead(A_RXD, rd); chk("R5 pop byte", rd, 32'h3C);
    chk("R9 irq clears after pop", {31'b0, irq}, 32'd0);
    regRead(A_RXD, rd); chk("R5 empty read", rd, 32'h8000_0000);
    regWrite(A_IE, 32'd0);

    // R8: read-only pending register and receive threshold
    regWrite(A_IP, 32'hFFFF_FFFF);
    regRead(A_IP, rd); chk("R8 write ignored", rd, 32'd0);
    regWrite(A_RXC, 32'h0002_0001);
    sendByte(8'h01, 1'b1); sendByte(8'h02, 1'b1);
    regRead(A_IP, rd); chk("R8 rx count 2 not above 2", rd, 32'd0);
    sendByte(8'h03, 1'b1);
    regRead(A_IP, rd); chk("R8 rx count 3 above 2", rd, 32'd2);
    for (int i = 1; i <= 3; i++) begin
      regRead(A_RXD, rd); chk("R5 rx order", rd, i);
    end

    // R6: framing error and disabled receive
    regWrite(A_RXC, 32'd1);
    sendByte(8'h55, 1'b0);
    regRead(A_RXD, rd); chk("R6 bad stop discarded", rd, 32'h8000_0000);
    regWrite(A_RXC, 32'd0);
    sendByte(8'h77, 1'b1);
    regWrite(A_RXC, 32'd1);
    regRead(A_RXD, rd); chk("R6 disabled ignored", rd, 32'h8000_0000);

    // R7: receive overflow
    for (int i = 0; i < 9; i++) sendByte(8'h40 + 8'(i), 1'b1);
    for (int i = 0; i < 8; i++) begin
      regRead(A_RXD, rd); chk("R7 kept order", rd, 32'h40 + i);
    end
    regRead(A_RXD, rd); chk("R7 ninth discarded", rd, 32'h8000_0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule